// File: doc/BRIEF.md
# Three-Line Multi-Slave Bus Handshake

The block connects one bus master to several slaves over a shared address/data bus controlled by a strobe line and two acknowledge lines. Each acknowledge line is the logical AND of the release outputs of all slaves. A line therefore goes high only when every slave has released it, and any slave that has not yet responded keeps it low.

Transfers are two-edge. Each toggle of the strobe, rising or falling, launches one word. Successive words are confirmed on alternating acknowledge lines. The master waits only for a rising edge on the line that belongs to the current word. Because falling edges are never used for synchronisation, a slow slave cannot be lost. When a slave accepts a word, it drops its release on the line it is not using. That line is then low and ready for the following word.

On the master side there is a valid/ready word interface. Each slave shows the last word it captured together with a one-cycle capture pulse. Each slave also takes its own response delay as an input, so the speed mix of the slaves can be set per slave.

Top module: `hs3_bus`

## Requirements
- R1: After reset, send_ready_o is high, strobe_o is low, both ack_o bits are low, and every slave word output is zero.
- R2: A word is accepted on a clock edge where send_valid_i and send_ready_o are both high. send_ready_o is low from the next cycle on, and bus_data_o carries the accepted word.
- R3: strobe_o toggles exactly once per accepted word, one cycle after acceptance. Both polarities of the toggle carry words, so strobe_o is high after an odd number of words.
- R4: Each slave detects a strobe toggle through a two-flop synchroniser. It then captures bus_data_o into its slot of slv_word_o and raises its slot of slv_word_vld_o for exactly one cycle.
- R5: A slave with delay d sets its release on the current line d+1 cycles after capture. At capture it clears its release on the other line.
- R6: Each ack_o bit is high only when all slaves have released that line.
- R7: Words alternate between the lines. Words 0, 2, 4, … are confirmed on ack_o[0] and words 1, 3, … on ack_o[1]. At completion ack_o is 2'b01 or 2'b10 respectively, and the two bits are never high together.
- R8: The master completes a word only on a rising edge of the expected line, seen through a two-flop synchroniser. send_ready_o returns high 8+dmax cycles after the accepting edge, where dmax is the largest slave delay.
- R9: strobe_o changes only while a word is in flight, never while the master is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| send_valid_i | input | 1 | Master has a word to send |
| send_data_i | input | DATA_W | Word to send |
| send_ready_o | output | 1 | Master can accept a word |
| slv_delay_i | input | N_SLV*DLY_W | Response delay per slave, slave s at bits [s*DLY_W +: DLY_W] |
| bus_data_o | output | DATA_W | Shared address/data bus |
| strobe_o | output | 1 | Strobe line |
| ack_o | output | 2 | Acknowledge lines, AND of all slave releases |
| slv_word_o | output | N_SLV*DATA_W | Last word captured by each slave |
| slv_word_vld_o | output | N_SLV | One-cycle capture pulse per slave |

## Verification
The bench builds the block with three slaves, 8-bit words and 3-bit delays. It sweeps all 512 delay combinations, sending two words per combination. Every combination therefore puts the slowest slave at every position with every delay, and words run on both strobe polarities and on both acknowledge lines. Completion latency is predicted from the largest delay in each combination, so an early release from a slow slave or an early completion by the master shows up as a cycle error.

// File: rtl/hs3_pkg.sv
package hs3_pkg;
  typedef enum logic [1:0] {
    M_IDLE   = 2'd0,
    M_LAUNCH = 2'd1,
    M_WAIT   = 2'd2
  } mst_state_e;
  localparam int unsigned NUM_ACK = 2;
endpackage

// File: rtl/hs3_sync.sv
module hs3_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end
  assign q_o = sync_q;
endmodule

// File: rtl/hs3_master.sv
module hs3_master
  import hs3_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               send_valid_i,
  input  logic [DATA_W-1:0]  send_data_i,
  output logic               send_ready_o,
  input  logic [NUM_ACK-1:0] ack_i,
  output logic [DATA_W-1:0]  bus_data_o,
  output logic               strobe_o
);
  mst_state_e         state_q;
  logic [DATA_W-1:0]  data_q;
  logic               strb_q;
  logic               sel_q;
  logic [NUM_ACK-1:0] ack_sync, ack_prev_q, ack_rise;

  hs3_sync #(.W(NUM_ACK)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_i),
    .q_o   (ack_sync)
  );

  // only rising edges are trusted
  assign ack_rise = ack_sync & ~ack_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= M_IDLE;
      data_q     <= '0;
      strb_q     <= 1'b0;
      sel_q      <= 1'b0;
      ack_prev_q <= '0;
    end else begin
      ack_prev_q <= ack_sync;
      unique case (state_q)
        M_IDLE: if (send_valid_i) begin
          data_q  <= send_data_i;
          state_q <= M_LAUNCH;
        end
        M_LAUNCH: begin
          strb_q  <= ~strb_q;
          state_q <= M_WAIT;
        end
        M_WAIT: if (ack_rise[sel_q]) begin
          sel_q   <= ~sel_q;
          state_q <= M_IDLE;
        end
        default: state_q <= M_IDLE;
      endcase
    end
  end

  assign send_ready_o = (state_q == M_IDLE);
  assign bus_data_o   = data_q;
  assign strobe_o     = strb_q;
endmodule

// File: rtl/hs3_slave.sv
module hs3_slave
  import hs3_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DLY_W  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               strobe_i,
  input  logic [DATA_W-1:0]  bus_data_i,
  input  logic [DLY_W-1:0]   delay_i,
  output logic [NUM_ACK-1:0] rel_o,
  output logic [DATA_W-1:0]  word_o,
  output logic               word_vld_o
);
  logic               strb_sync, strb_prev_q, strb_edge;
  logic [NUM_ACK-1:0] rel_q;
  logic [DATA_W-1:0]  word_q;
  logic               vld_q, busy_q, cur_q;
  logic [DLY_W-1:0]   cnt_q;

  hs3_sync #(.W(1)) u_strb_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (strobe_i),
    .q_o   (strb_sync)
  );

  assign strb_edge = strb_sync ^ strb_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_prev_q <= 1'b0;
      rel_q       <= '0;
      word_q      <= '0;
      vld_q       <= 1'b0;
      busy_q      <= 1'b0;
      cur_q       <= 1'b0;
      cnt_q       <= '0;
    end else begin
      strb_prev_q <= strb_sync;
      vld_q       <= 1'b0;
      if (strb_edge) begin
        word_q        <= bus_data_i;
        vld_q         <= 1'b1;
        cnt_q         <= delay_i;
        busy_q        <= 1'b1;
        rel_q[~cur_q] <= 1'b0; // arm the other line for the next word
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          rel_q[cur_q] <= 1'b1;
          busy_q       <= 1'b0;
          cur_q        <= ~cur_q;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign rel_o      = rel_q;
  assign word_o     = word_q;
  assign word_vld_o = vld_q;
endmodule

// File: rtl/hs3_bus.sv
module hs3_bus
  import hs3_pkg::*;
#(
  parameter int unsigned N_SLV  = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DLY_W  = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      send_valid_i,
  input  logic [DATA_W-1:0]         send_data_i,
  output logic                      send_ready_o,
  input  logic [N_SLV*DLY_W-1:0]    slv_delay_i,
  output logic [DATA_W-1:0]         bus_data_o,
  output logic                      strobe_o,
  output logic [NUM_ACK-1:0]        ack_o,
  output logic [N_SLV*DATA_W-1:0]   slv_word_o,
  output logic [N_SLV-1:0]          slv_word_vld_o
);
  logic [N_SLV-1:0][NUM_ACK-1:0] rel;
  logic [NUM_ACK-1:0]            ack_tie;

  hs3_master #(.DATA_W(DATA_W)) u_master (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .send_valid_i(send_valid_i),
    .send_data_i (send_data_i),
    .send_ready_o(send_ready_o),
    .ack_i       (ack_tie),
    .bus_data_o  (bus_data_o),
    .strobe_o    (strobe_o)
  );

  for (genvar s = 0; s < N_SLV; s++) begin : g_slv
    hs3_slave #(.DATA_W(DATA_W), .DLY_W(DLY_W)) u_slave (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .strobe_i  (strobe_o),
      .bus_data_i(bus_data_o),
      .delay_i   (slv_delay_i[s*DLY_W +: DLY_W]),
      .rel_o     (rel[s]),
      .word_o    (slv_word_o[s*DATA_W +: DATA_W]),
      .word_vld_o(slv_word_vld_o[s])
    );
  end

  // wired tie: any slave holding low keeps the line low
  always_comb begin
    ack_tie = '1;
    for (int s = 0; s < N_SLV; s++) ack_tie &= rel[s];
  end

  assign ack_o = ack_tie;
endmodule

// File: rtl/hs3_bus_chk.sv
module hs3_bus_chk #(
  parameter int unsigned N_SLV = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             send_valid_i,
  input logic             send_ready_o,
  input logic             strobe_o,
  input logic [1:0]       ack_o,
  input logic [N_SLV-1:0] slv_word_vld_o
);
  assert_ready_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_valid_i && send_ready_o) |=> !send_ready_o);

  assert_strobe_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o != $past(strobe_o)) |-> (!send_ready_o && !$past(send_ready_o)));

  assert_ack_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_o[0] && ack_o[1]));

  assert_done_on_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(send_ready_o) |-> (ack_o != 2'b00));

  for (genvar s = 0; s < N_SLV; s++) begin : g_pulse
    assert_vld_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slv_word_vld_o[s] |=> !slv_word_vld_o[s]);
  end
endmodule

bind hs3_bus hs3_bus_chk #(.N_SLV(N_SLV)) u_hs3_bus_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .send_valid_i  (send_valid_i),
  .send_ready_o  (send_ready_o),
  .strobe_o      (strobe_o),
  .ack_o         (ack_o),
  .slv_word_vld_o(slv_word_vld_o)
);

// File: tb/hs3_bus_bench.sv
module hs3_bus_bench;
  localparam int unsigned N_SLV  = 3;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned DLY_W  = 3;
  localparam int unsigned N_CMB  = 1 << (N_SLV * DLY_W);

  logic                      clk_i = 1'b0;
  logic                      rst_ni = 1'b0;
  logic                      send_valid_i = 1'b0;
  logic [DATA_W-1:0]         send_data_i = '0;
  logic                      send_ready_o;
  logic [N_SLV*DLY_W-1:0]    slv_delay_i = '0;
  logic [DATA_W-1:0]         bus_data_o;
  logic                      strobe_o;
  logic [1:0]                ack_o;
  logic [N_SLV*DATA_W-1:0]   slv_word_o;
  logic [N_SLV-1:0]          slv_word_vld_o;

  int n_chk = 0;
  int n_fail = 0;
  int n_words = 0;
  int vld_cnt [N_SLV];
  int cyc = 0;

  always #2 clk_i = ~clk_i;

  hs3_bus #(.N_SLV(N_SLV), .DATA_W(DATA_W), .DLY_W(DLY_W)) u_hs3_bus (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .send_valid_i  (send_valid_i),
    .send_data_i   (send_data_i),
    .send_ready_o  (send_ready_o),
    .slv_delay_i   (slv_delay_i),
    .bus_data_o    (bus_data_o),
    .strobe_o      (strobe_o),
    .ack_o         (ack_o),
    .slv_word_o    (slv_word_o),
    .slv_word_vld_o(slv_word_vld_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni)
      for (int s = 0; s < N_SLV; s++) if (slv_word_vld_o[s]) vld_cnt[s]++;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic send_word(input logic [DATA_W-1:0] w, input int dmax);
    int lows;
    @(negedge clk_i);
    send_valid_i = 1'b1;
    send_data_i  = w;
    @(posedge clk_i);
    @(negedge clk_i);
    send_valid_i = 1'b0;
    chk(!send_ready_o, "R2 ready drop", send_ready_o, 0);
    chk(bus_data_o == w, "R2 bus data", bus_data_o, w);
    lows = 0;
    while (!send_ready_o && lows < 64) begin
      lows++;
      @(negedge clk_i);
    end
    n_words++;
    chk(lows == 8 + dmax, "R8 completion latency", lows, 8 + dmax);
    for (int s = 0; s < N_SLV; s++)
      chk(slv_word_o[s*DATA_W +: DATA_W] == w, "R4 slave word",
          slv_word_o[s*DATA_W +: DATA_W], w);
    // R7 line alternation, R6 all released on the expected line
    chk(ack_o == ((n_words % 2) ? 2'b01 : 2'b10), "R7 ack pattern", ack_o,
        (n_words % 2) ? 1 : 2);
    chk(strobe_o == n_words[0], "R3 strobe polarity", strobe_o, n_words % 2);
  endtask

  initial begin
    for (int s = 0; s < N_SLV; s++) vld_cnt[s] = 0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(send_ready_o == 1'b1, "R1 ready", send_ready_o, 1);
    chk(strobe_o == 1'b0, "R1 strobe", strobe_o, 0);
    chk(ack_o == 2'b00, "R1 ack", ack_o, 0);
    chk(slv_word_o == '0, "R1 slave words", int'(slv_word_o), 0);
    rst_ni = 1'b1;
    for (int c = 0; c < N_CMB; c++) begin
      int dmax;
      dmax = 0;
      @(negedge clk_i);
      slv_delay_i = c[N_SLV*DLY_W-1:0];
      for (int s = 0; s < N_SLV; s++) begin
        int d;
        d = (c >> (s * DLY_W)) & ((1 << DLY_W) - 1);
        if (d > dmax) dmax = d;
      end
      // R5 per-slave delay, R6 slowest slave governs
      for (int w = 0; w < 2; w++)
        send_word(DATA_W'((c * 37 + w * 91 + 5) & 8'hFF), dmax);
    end
    repeat (4) @(negedge clk_i);
    for (int s = 0; s < N_SLV; s++)
      chk(vld_cnt[s] == n_words, "R4 capture pulse count", vld_cnt[s], n_words);
    // R9 strobe idle while no word in flight
    begin
      logic sv;
      sv = strobe_o;
      repeat (20) @(negedge clk_i);
      chk(strobe_o == sv, "R9 strobe idle", strobe_o, sv);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule